// File: doc/BRIEF.md
# Multi-Channel Power-Up Sequencer

This block brings up three regulator channels in a controlled order once the enable input goes high. Each channel that is chosen by the selection mask first waits for its own programmable delay. It then raises its run enable and ramps a digital reference level from zero up to its programmed target, taking a programmable soft-start time to do so. The block counts all timing in periods of the switching clock, which arrives as a one-cycle tick pulse. Delays and ramp lengths therefore scale with the switching frequency. Channels left out of the mask are skipped. They keep their run enable low and their reference at zero.

Every channel runs its own state machine with five states. CH_IDLE means disabled. CH_SKIP means not selected in this run. CH_WAIT means the delay is being counted. CH_RAMP means soft-start is in progress, with run high. CH_DONE means the reference is held at the target. The transitions are as follows. Start with the channel selected and a zero delay code goes to CH_RAMP. Start with the channel selected and a nonzero delay code goes to CH_WAIT. Start with the channel not selected goes to CH_SKIP. From CH_WAIT, the channel moves to CH_RAMP when the delay count ends. From CH_RAMP, it moves to CH_DONE when the soft-start count ends. Enable low sends any state to CH_IDLE. A start event re-enters the sequence from any state. A start event is either a rising edge of enable, or a restart pulse while enable is high. A separate restart input, driven by a fault controller, re-runs the whole sequence. The sequencing-done output is high once every selected channel has finished its ramp.

Top module: `pwr_sequencer`

## Requirements
- R1: After reset, run_en and all reference levels are zero and seq_done is low.
- R2: A start event occurs only at a clock edge where enable is high and was low at the previous edge, or where enable and restart are both high. A channel whose chan_sel bit is 0 at that start keeps run_en low and its reference at zero for the whole run.
- R3: A selected channel with a 3-bit delay code d raises run_en exactly d×DLY_STEP ticks after the start edge. Its reference stays at 0 until then. Ticks that coincide with the start edge are not counted.
- R4: A soft-start code s gives a ramp of exactly (s+1)×SS_STEP ticks. The channel reaches its target and enters the done state at the last tick of the ramp.
- R5: k ticks into the ramp, the reference equals floor(T×k/L), where T is the target level and L is the ramp length. The reference never falls during a run and never exceeds T.
- R6: Reference levels are in steps of 50 mV, where 0 means 0 V. The target is 16 + code, with code taken from the channel's 7-bit vout_code field. When the channel's ext_fb bit is 1, the target is 16 (0.8 V) whatever the code.
- R7: Only tick pulses advance delays and ramps. With no tick, all outputs hold their values.
- R8: One clock after enable goes low, every channel is idle, with run_en low, reference zero and seq_done low.
- R9: seq_done is high exactly when every selected channel has finished its ramp. With an empty mask, seq_done rises at the start edge itself.
- R10: A restart pulse while enable is high re-runs the whole delay and soft-start sequence from zero.
- R11: A restart pulse while enable is low has no effect, and all outputs stay at zero.
- R12: The mask, codes and targets are captured at the start edge. Changes made later have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_tick | input | 1 | One-cycle pulse per switching period |
| enable | input | 1 | Sequence enable, active high |
| restart | input | 1 | Re-run request from the fault controller |
| chan_sel | input | NUM_CH | Channel selection mask |
| delay_code | input | 3*NUM_CH | Per-channel delay code, channel i at [3i+2:3i] |
| ramp_code | input | 3*NUM_CH | Per-channel soft-start code, channel i at [3i+2:3i] |
| vout_code | input | 7*NUM_CH | Per-channel target code, channel i at [7i+6:7i] |
| ext_fb | input | NUM_CH | Per-channel external-feedback select |
| run_en | output | NUM_CH | Per-channel regulator run enable |
| ref_level | output | 8*NUM_CH | Per-channel reference level, channel i at [8i+7:8i] |
| seq_done | output | 1 | All selected channels have finished their ramp |

## Verification
A table of configurations is run with the switching tick arriving every other clock, and every output is compared on every tick against the closed-form timing and ramp formulas. The configurations cover three things. Staggered delays show that each channel counts from the common start edge. Zero delay with maximum ramp, and the reverse, show that the delay field and the ramp field are decoded separately. Sparse masks and external-feedback bits show that skipped channels and code-independent targets behave correctly. Directed runs then check the remaining cases: enable dropping mid-ramp, restart with enable high and with enable low, ticks withheld mid-ramp, configuration changes after start, and an empty mask. Each one separates a behaviour that a single clean power-up would not expose.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int REF_W    = 8;
    localparam int CODE_W   = 7;
    localparam int FLD_W    = 3;
    localparam int BASE_LVL = 16;

    typedef enum logic [2:0] {
        CH_IDLE = 3'd0,
        CH_SKIP = 3'd1,
        CH_WAIT = 3'd2,
        CH_RAMP = 3'd3,
        CH_DONE = 3'd4
    } ch_state_t;

    // Target level in 50 mV units; external feedback pins it at the 0.8 V base.
    function automatic logic [REF_W-1:0] target_level(input logic ext,
                                                      input logic [CODE_W-1:0] code);
        logic [REF_W-1:0] lvl;
        if (ext) lvl = REF_W'(BASE_LVL);
        else     lvl = REF_W'(BASE_LVL) + REF_W'(code);
        return lvl;
    endfunction

endpackage

// File: rtl/pwrseq_trigger.sv
module pwrseq_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic restart_i,
    output logic start_o
);

    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= enable_i;
    end

    always_comb begin
        start_o = enable_i & (~en_q | restart_i);
    end

    // R2: a start never happens while enable is low
    a_r2_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> enable_i);

    // R10: restart with enable held high yields a start event
    a_r10_restart_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && restart_i) |-> start_o);

endmodule

// File: rtl/pwrseq_ramp.sv
module pwrseq_ramp
    import pwrseq_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic             full_i,
    input  logic [REF_W-1:0] target_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [REF_W-1:0] level_o
);

    localparam int AW = ((LEN_W > REF_W) ? LEN_W : REF_W) + 1;

    logic [AW-1:0]    acc_q;
    logic [AW-1:0]    sum;
    logic [REF_W-1:0] lvl_q;

    always_comb begin
        sum = acc_q + AW'(target_i);
    end

    // Error accumulator: one level step each time the sum crosses the ramp length.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            lvl_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
            lvl_q <= '0;
        end else if (full_i) begin
            acc_q <= '0;
            lvl_q <= target_i;
        end else if (step_i) begin
            if (sum >= AW'(len_i)) begin
                acc_q <= sum - AW'(len_i);
                lvl_q <= lvl_q + REF_W'(1);
            end else begin
                acc_q <= sum;
            end
        end
    end

    assign level_o = lvl_q;

    // R5: the level never passes the captured target
    a_r5_level_capped: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= target_i);

endmodule

// File: rtl/pwrseq_channel.sv
module pwrseq_channel
    import pwrseq_pkg::*;
#(
    parameter int DLY_STEP = 5000,
    parameter int SS_STEP  = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              enable_i,
    input  logic              start_i,
    input  logic              sel_i,
    input  logic [FLD_W-1:0]  dly_code_i,
    input  logic [FLD_W-1:0]  ss_code_i,
    input  logic              ext_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              run_o,
    output logic              fin_o,
    output logic [REF_W-1:0]  ref_o
);

    localparam int MAXC = (1 << FLD_W);
    localparam int DCW  = $clog2((MAXC - 1) * DLY_STEP + 1);
    localparam int SCW  = $clog2(MAXC * SS_STEP + 1);
    localparam int CW   = (DCW > SCW) ? DCW : SCW;

    ch_state_t        st_q, st_d;
    logic [FLD_W-1:0] dly_q, ss_q;
    logic [REF_W-1:0] tgt_q;
    logic [CW-1:0]    cnt_q, dly_len, ss_len;
    logic             load;
    logic             cnt_clr, cnt_inc;
    logic             r_clr, r_step, r_full;

    assign load = enable_i & start_i;

    // Configuration captured at each start event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
            ss_q  <= '0;
            tgt_q <= '0;
        end else if (load) begin
            dly_q <= dly_code_i;
            ss_q  <= ss_code_i;
            tgt_q <= target_level(ext_i, code_i);
        end
    end

    assign dly_len = CW'(dly_q) * CW'(DLY_STEP);
    assign ss_len  = (CW'(ss_q) + CW'(1)) * CW'(SS_STEP);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // Next state and counter / ramp control
    always_comb begin
        st_d    = st_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        r_clr   = 1'b0;
        r_step  = 1'b0;
        r_full  = 1'b0;
        if (!enable_i) begin
            st_d    = CH_IDLE;
            cnt_clr = 1'b1;
            r_clr   = 1'b1;
        end else if (start_i) begin
            cnt_clr = 1'b1;
            r_clr   = 1'b1;
            if (!sel_i)                 st_d = CH_SKIP;
            else if (dly_code_i == '0)  st_d = CH_RAMP;
            else                        st_d = CH_WAIT;
        end else begin
            unique case (st_q)
                CH_IDLE, CH_SKIP, CH_DONE: begin
                end
                CH_WAIT: begin
                    if (tick_i) begin
                        if (cnt_q == dly_len - CW'(1)) begin
                            st_d    = CH_RAMP;
                            cnt_clr = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                CH_RAMP: begin
                    if (tick_i) begin
                        r_step = 1'b1;
                        if (cnt_q == ss_len - CW'(1)) begin
                            st_d    = CH_DONE;
                            cnt_clr = 1'b1;
                            r_full  = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                default: st_d = CH_IDLE;
            endcase
        end
    end

    // Shared delay / soft-start tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_clr) cnt_q <= '0;
        else if (cnt_inc) cnt_q <= cnt_q + CW'(1);
    end

    // Outputs
    always_comb begin
        run_o = 1'b0;
        fin_o = 1'b0;
        unique case (st_q)
            CH_IDLE: begin end
            CH_SKIP: fin_o = 1'b1;
            CH_WAIT: begin end
            CH_RAMP: run_o = 1'b1;
            CH_DONE: begin
                run_o = 1'b1;
                fin_o = 1'b1;
            end
            default: begin end
        endcase
    end

    pwrseq_ramp #(.LEN_W(CW)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (r_clr),
        .step_i   (r_step),
        .full_i   (r_full),
        .target_i (tgt_q),
        .len_i    (ss_len),
        .level_o  (ref_o)
    );

    // R3: reference is parked at zero during the delay
    a_r3_wait_ref_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_WAIT) |-> (ref_o == '0));

    // R4: a finished channel sits exactly on its target
    a_r4_done_on_target: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_DONE) |-> (ref_o == tgt_q));

    // R5: reference is non-decreasing within one run
    a_r5_ref_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && $past(run_o) && !$past(start_i) && $past(enable_i)) |-> (ref_o >= $past(ref_o)));

    // R7: with no tick and no start, nothing moves
    a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !start_i && enable_i) |=> ($stable(ref_o) && $stable(run_o)));

    // R8: enable low clears the channel on the next edge
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (ref_o == '0 && !run_o));

endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer
    import pwrseq_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int DLY_STEP = 5000,
    parameter int SS_STEP  = 500
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sw_tick,
    input  logic                      enable,
    input  logic                      restart,
    input  logic [NUM_CH-1:0]         chan_sel,
    input  logic [NUM_CH*FLD_W-1:0]   delay_code,
    input  logic [NUM_CH*FLD_W-1:0]   ramp_code,
    input  logic [NUM_CH*CODE_W-1:0]  vout_code,
    input  logic [NUM_CH-1:0]         ext_fb,
    output logic [NUM_CH-1:0]         run_en,
    output logic [NUM_CH*REF_W-1:0]   ref_level,
    output logic                      seq_done
);

    logic              start;
    logic [NUM_CH-1:0] fin;

    pwrseq_trigger u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable),
        .restart_i (restart),
        .start_o   (start)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwrseq_channel #(
            .DLY_STEP (DLY_STEP),
            .SS_STEP  (SS_STEP)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (sw_tick),
            .enable_i   (enable),
            .start_i    (start),
            .sel_i      (chan_sel[g]),
            .dly_code_i (delay_code[g*FLD_W +: FLD_W]),
            .ss_code_i  (ramp_code[g*FLD_W +: FLD_W]),
            .ext_i      (ext_fb[g]),
            .code_i     (vout_code[g*CODE_W +: CODE_W]),
            .run_o      (run_en[g]),
            .fin_o      (fin[g]),
            .ref_o      (ref_level[g*REF_W +: REF_W])
        );
    end

    assign seq_done = &fin;

    // R9: done is withdrawn once enable is removed
    a_r9_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !seq_done);

    // R11: restart with enable low leaves every channel off
    a_r11_restart_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && restart) |=> (run_en == '0));

    // R1: nothing runs in the first cycle out of reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (run_en == '0 && !seq_done));

endmodule

// File: tb/pwr_sequencer_tb_top.sv
module pwr_sequencer_tb_top;

    localparam int NCH   = 3;
    localparam int DSTEP = 40;
    localparam int SSTEP = 150;
    localparam int NV    = 6;

    // Vector table: mask, delay codes {c2,c1,c0}, ramp codes, target codes, ext bits
    localparam logic [2:0]  VSEL [NV] = '{3'b111, 3'b101, 3'b010, 3'b111, 3'b110, 3'b011};
    localparam logic [8:0]  VDLY [NV] = '{{3'd2,3'd1,3'd0}, {3'd7,3'd0,3'd3}, {3'd0,3'd7,3'd0},
                                          {3'd0,3'd0,3'd0}, {3'd1,3'd5,3'd0}, {3'd4,3'd6,3'd2}};
    localparam logic [8:0]  VSS  [NV] = '{{3'd2,3'd1,3'd0}, {3'd0,3'd0,3'd7}, {3'd0,3'd4,3'd0},
                                          {3'd0,3'd0,3'd0}, {3'd6,3'd3,3'd7}, {3'd3,3'd1,3'd5}};
    localparam logic [20:0] VCODE[NV] = '{{7'h7F,7'h0A,7'h05}, {7'h7F,7'h40,7'h00}, {7'h00,7'h33,7'h00},
                                          {7'h30,7'h20,7'h10}, {7'h00,7'h7F,7'h01}, {7'h11,7'h01,7'h22}};
    localparam logic [2:0]  VEXT [NV] = '{3'b000, 3'b101, 3'b000, 3'b000, 3'b000, 3'b010};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        restart = 1'b0;
    logic        tick_on = 1'b0;
    logic        ph = 1'b0;
    logic [2:0]  chan_sel = '0;
    logic [8:0]  dly = '0;
    logic [8:0]  ss = '0;
    logic [20:0] code = '0;
    logic [2:0]  ext = '0;
    logic [2:0]  run_en;
    logic [23:0] ref_level;
    logic        seq_done;
    logic        sw_tick;

    int unsigned tick_cnt = 0;
    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;
    always @(negedge clk) ph <= ~ph;
    assign sw_tick = tick_on & ph;
    always @(posedge clk) if (sw_tick) tick_cnt <= tick_cnt + 1;

    pwr_sequencer #(
        .NUM_CH   (NCH),
        .DLY_STEP (DSTEP),
        .SS_STEP  (SSTEP)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_tick    (sw_tick),
        .enable     (enable),
        .restart    (restart),
        .chan_sel   (chan_sel),
        .delay_code (dly),
        .ramp_code  (ss),
        .vout_code  (code),
        .ext_fb     (ext),
        .run_en     (run_en),
        .ref_level  (ref_level),
        .seq_done   (seq_done)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(run_en == 3'b000, req, "run_en", int'(run_en), 0);
        check(ref_level == '0, req, "ref_level", int'(ref_level), 0);
        check(seq_done == 1'b0, req, "seq_done", int'(seq_done), 0);
    endtask

    // Called at the negedge right after the start edge; compares every tick to the formulas
    task automatic sweep(input string req, input logic [2:0] s, input logic [8:0] d,
                         input logic [8:0] sc, input logic [20:0] c, input logic [2:0] e);
        int dl[3];
        int ln[3];
        int tg[3];
        int maxe;
        int unsigned t0;
        maxe = 0;
        t0 = tick_cnt;
        for (int i = 0; i < 3; i++) begin
            dl[i] = int'(d[3*i +: 3]) * DSTEP;
            ln[i] = (int'(sc[3*i +: 3]) + 1) * SSTEP;
            tg[i] = e[i] ? 16 : 16 + int'(c[7*i +: 7]);
            if (s[i] && (dl[i] + ln[i] > maxe)) maxe = dl[i] + ln[i];
        end
        for (int k = 0; k <= maxe; k++) begin
            bit ok;
            while (tick_cnt != t0 + k) @(negedge clk);
            ok = 1'b1;
            for (int i = 0; i < 3; i++) begin
                int er;
                bit rr;
                rr = s[i] && (k >= dl[i]);
                if (!s[i] || k < dl[i])       er = 0;
                else if (k >= dl[i] + ln[i])  er = tg[i];
                else                          er = (tg[i] * (k - dl[i])) / ln[i];
                if (run_en[i] != rr || int'(ref_level[8*i +: 8]) != er) begin
                    ok = 1'b0;
                    if (errors < 12)
                        $display("FAIL %s ch%0d tick %0d: actual run=%0d ref=%0d expected run=%0d ref=%0d",
                                 req, i, k, run_en[i], ref_level[8*i +: 8], rr, er);
                end
            end
            if (seq_done != (k >= maxe)) begin
                ok = 1'b0;
                if (errors < 12)
                    $display("FAIL %s R9 tick %0d: actual done=%0d expected done=%0d",
                             req, k, seq_done, (k >= maxe));
            end
            checks++;
            if (!ok) errors++;
        end
    endtask

    task automatic load_vec(input int v);
        chan_sel = VSEL[v];
        dly      = VDLY[v];
        ss       = VSS[v];
        code     = VCODE[v];
        ext      = VEXT[v];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [23:0] held_ref;
        logic [2:0]  held_run;
        int unsigned t0;

        // R1: outputs quiet in and just after reset
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        tick_on = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_idle("R1");

        // Table walk: R2 R3 R4 R5 R6 R9 on each entry
        for (int v = 0; v < NV; v++) begin
            load_vec(v);
            enable = 1'b1;
            @(negedge clk);
            sweep("R2/R3/R4/R5/R6", VSEL[v], VDLY[v], VSS[v], VCODE[v], VEXT[v]);
            enable = 1'b0;
            @(negedge clk);
            check_idle("R8");
            @(negedge clk);
        end

        // R10: restart after completion replays the sequence
        load_vec(0);
        enable = 1'b1;
        @(negedge clk);
        sweep("R10 first", VSEL[0], VDLY[0], VSS[0], VCODE[0], VEXT[0]);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        sweep("R10 rerun", VSEL[0], VDLY[0], VSS[0], VCODE[0], VEXT[0]);

        // R8: enable dropped mid-ramp
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        t0 = tick_cnt;
        while (tick_cnt != t0 + 300) @(negedge clk);
        check(run_en[2] == 1'b1, "R8", "ch2 running before drop", int'(run_en[2]), 1);
        enable = 1'b0;
        @(negedge clk);
        check_idle("R8");

        // R11: restart with enable low is ignored
        restart = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check_idle("R11");
        end
        restart = 1'b0;
        @(negedge clk);
        check_idle("R11");

        // R7: withhold ticks mid-ramp on a long single-channel ramp
        chan_sel = 3'b001; dly = '0; ss = {3'd0,3'd0,3'd7}; code = {7'd0,7'd0,7'h7F}; ext = '0;
        enable = 1'b1;
        @(negedge clk);
        t0 = tick_cnt;
        while (tick_cnt != t0 + 500) @(negedge clk);
        tick_on = 1'b0;
        held_ref = ref_level;
        held_run = run_en;
        check(int'(held_ref[7:0]) == (143 * 500) / 1200, "R7", "ref before hold",
              int'(held_ref[7:0]), (143 * 500) / 1200);
        repeat (40) @(negedge clk);
        check(ref_level == held_ref, "R7", "ref held", int'(ref_level), int'(held_ref));
        check(run_en == held_run, "R7", "run held", int'(run_en), int'(held_run));
        check(seq_done == 1'b0, "R7", "done held low", int'(seq_done), 0);
        tick_on = 1'b1;
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);

        // R12: inputs changed after start do not alter the run
        load_vec(1);
        enable = 1'b1;
        @(negedge clk);
        load_vec(4);
        sweep("R12", VSEL[1], VDLY[1], VSS[1], VCODE[1], VEXT[1]);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);

        // R9: empty mask completes at the start edge
        chan_sel = 3'b000;
        check(seq_done == 1'b0, "R9", "done before start", int'(seq_done), 0);
        enable = 1'b1;
        @(negedge clk);
        check(seq_done == 1'b1, "R9", "empty-mask done", int'(seq_done), 1);
        check(run_en == 3'b000, "R9", "empty-mask run", int'(run_en), 0);
        sweep("R9", 3'b000, VDLY[0], VSS[0], VCODE[0], VEXT[0]);
        enable = 1'b0;
        @(negedge clk);
        check_idle("R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule